// File: doc/BRIEF.md
# Hashed Page Table Search Engine

The engine translates a 32-bit effective address into a real address by looking it up in an in-memory hashed page table. A lookup takes the segment's virtual segment ID (VSID), the effective address and a store flag. From these it derives a 31-bit compare word and a 19-bit hash, then scans an eight-entry group of the table one word at a time through a request/acknowledge memory port.

If nothing in the first (primary) group matches, the engine scans a second (secondary) group, located by the complemented hash. On a hit it returns three things: the entry's byte offset within the table, the entry's updated second word, and the real address. It writes the second word back only when the referenced or changed bit actually changes.

A caller starts a lookup with a single-cycle request while the engine is idle. It reads the results once `done_o` pulses. Segment register decoding and access-permission policy sit in neighbouring blocks.

Top module: `hpt_search`

## Requirements
- R1: After reset `busy_o`, `done_o`, `hit_o`, `wr_allow_o` and `mem_req_o` are all 0.
- R2: Group offsets are computed from the page index `pidx = ea[27:12]` and `hash = vsid[18:0] ^ {3'b0, pidx}`. The primary group offset is `({hash,6'b0}) & tbl_mask_i` and the secondary one is `({~hash,6'b0}) & tbl_mask_i`. Entry k of a group occupies bytes `off + 8k` (first word) and `off + 8k + 4` (second word). Each memory address is `tbl_base_i + offset`. The first words are read in ascending k, the primary group first.
- R3: A first word matches only when all of the following hold: bit 31 (valid) is 1; bit 6 (secondary flag) equals the pass (0 primary, 1 secondary); and bits 30:7 and 5:0 equal the compare word `{vsid, 1'b0, ea[27:22]}` with bit 6 ignored.
- R4: The lowest-indexed matching entry of a group wins, and the scan stops there.
- R5: The secondary group is scanned only after all eight primary first words miss.
- R6: When both groups miss, after 16 reads, `done_o` pulses with `hit_o` = 0 and no write is made.
- R7: On a hit the new second word is the old one with bit 8 (referenced) set, plus bit 7 (changed) when the access is a store. It is written back once to the entry's second-word address only if it differs from the old value.
- R8: `wr_allow_o` is 1 after a store hit and 0 after a non-store hit or a miss.
- R9: On a hit `real_addr_o` is `{second_word[31:12], ea[11:0]}`.
- R10: On a hit `pte_off_o` is the entry's byte offset (group offset + 8k) and `pte_word_o` is the updated second word.
- R11: A request raised while a lookup is in progress is ignored: it starts no reads and produces no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a lookup (accepted when idle) |
| req_vsid_i | input | 24 | Virtual segment ID |
| req_ea_i | input | 32 | Effective address |
| req_store_i | input | 1 | Access is a store |
| tbl_base_i | input | 32 | Table byte base address |
| tbl_mask_i | input | 32 | Table offset mask |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Last lookup found an entry |
| pte_off_o | output | 32 | Byte offset of the found entry |
| pte_word_o | output | 32 | Updated second word of the found entry |
| real_addr_o | output | 32 | Translated real address |
| wr_allow_o | output | 1 | Write permission may be kept |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory access completed |

## Verification
The hardest case to reach is a secondary-group hit that sits behind primary entries that nearly match. These are entries that differ only in the valid bit, the secondary flag or a single compare bit. There is also a secondary-group entry that would match except that its flag is clear.

The bench reaches these cases by writing its memory model directly before each lookup. It places such decoys ahead of the true entry. Random lookups then scatter a hit into either pass or into neither, over a memory that answers with random latency.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_TAG,
    W_DATA,
    W_UPD,
    W_FIN
  } walk_st_e;

  localparam int unsigned PTE_W       = 32;
  localparam int unsigned ENTRY_BYTES = 8;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned V_BIT       = 31;
  localparam int unsigned H_BIT       = 6;
  localparam int unsigned REF_BIT     = 8;
  localparam int unsigned CHG_BIT     = 7;
  localparam int unsigned PAGE_BITS   = 12;
  localparam int unsigned SEG_BITS    = 4;
  localparam int unsigned API_SHIFT   = 10;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int unsigned VSID_W    = 24,
  parameter int unsigned EA_W      = 32,
  parameter int unsigned HASH_W    = 19,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRP_SHIFT = 6,
  localparam int unsigned PIDX_W   = EA_W - SEG_BITS - PAGE_BITS,
  localparam int unsigned API_W    = PIDX_W - API_SHIFT,
  localparam int unsigned CMP_W    = VSID_W + API_W + 1
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [CMP_W-1:0]  cmp_o,
  output logic [ADDR_W-1:0] prim_off_o,
  output logic [ADDR_W-1:0] sec_off_o
);
  logic [PIDX_W-1:0] pidx;
  logic [API_W-1:0]  api;
  logic [HASH_W-1:0] hash, hash_n;

  always_comb begin
    pidx   = ea_i[EA_W-SEG_BITS-1:PAGE_BITS];
    api    = pidx[PIDX_W-1:API_SHIFT];
    cmp_o  = {vsid_i, 1'b0, api};
    hash   = vsid_i[HASH_W-1:0] ^ HASH_W'(pidx);
    hash_n = ~hash;
    prim_off_o = (ADDR_W'(hash)   << GRP_SHIFT) & mask_i;
    sec_off_o  = (ADDR_W'(hash_n) << GRP_SHIFT) & mask_i;
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
#(
  parameter int unsigned CMP_W = 31
) (
  input  logic [PTE_W-1:0] tag_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             sec_i,
  output logic             hit_o
);
  logic [CMP_W-1:0] body;

  always_comb begin
    body        = tag_i[CMP_W-1:0];
    body[H_BIT] = 1'b0;
    hit_o = tag_i[V_BIT] && (tag_i[H_BIT] == sec_i) && (body == cmp_i);
  end
endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CMP_W   = 31,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [EA_W-1:0]   req_ea_i,
  input  logic              req_store_i,
  input  logic [CMP_W-1:0]  cmp_i,
  input  logic [ADDR_W-1:0] prim_off_i,
  input  logic [ADDR_W-1:0] sec_off_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              match_i,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              sec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] pte_off_o,
  output logic [PTE_W-1:0]  pte_word_o,
  output logic [EA_W-1:0]   real_addr_o,
  output logic              wr_allow_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i
);
  walk_st_e          st_q;
  logic [EA_W-1:0]   ea_q;
  logic              store_q;
  logic [CMP_W-1:0]  cmp_q;
  logic [ADDR_W-1:0] prim_q, sec_off_q, off_q;
  logic              sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic              hit_q, wr_allow_q;
  logic [PTE_W-1:0]  pte_q;
  logic [EA_W-1:0]   real_q;

  logic [ADDR_W-1:0] grp_off, entry_off;
  logic [PTE_W-1:0]  upd_word;

  always_comb begin
    grp_off   = sec_q ? sec_off_q : prim_q;
    entry_off = grp_off + (ADDR_W'(idx_q) << $clog2(ENTRY_BYTES));
    upd_word  = mem_rdata_i | (PTE_W'(1) << REF_BIT);
    if (store_q) upd_word = upd_word | (PTE_W'(1) << CHG_BIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= W_IDLE;
      ea_q       <= '0;
      store_q    <= 1'b0;
      cmp_q      <= '0;
      prim_q     <= '0;
      sec_off_q  <= '0;
      off_q      <= '0;
      sec_q      <= 1'b0;
      idx_q      <= '0;
      hit_q      <= 1'b0;
      wr_allow_q <= 1'b0;
      pte_q      <= '0;
      real_q     <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (req_valid_i) begin
          ea_q       <= req_ea_i;
          store_q    <= req_store_i;
          cmp_q      <= cmp_i;
          prim_q     <= prim_off_i;
          sec_off_q  <= sec_off_i;
          sec_q      <= 1'b0;
          idx_q      <= '0;
          hit_q      <= 1'b0;
          wr_allow_q <= 1'b0;
          st_q       <= W_TAG;
        end
        W_TAG: if (mem_ack_i) begin
          if (match_i) begin
            st_q <= W_DATA;
          end else if (idx_q == LAST_IDX) begin
            idx_q <= '0;
            if (sec_q) st_q <= W_FIN;
            else       sec_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        W_DATA: if (mem_ack_i) begin
          pte_q      <= upd_word;
          real_q     <= {mem_rdata_i[PTE_W-1:PAGE_BITS], ea_q[PAGE_BITS-1:0]};
          hit_q      <= 1'b1;
          wr_allow_q <= store_q;
          off_q      <= entry_off;
          st_q       <= (upd_word != mem_rdata_i) ? W_UPD : W_FIN;
        end
        W_UPD: if (mem_ack_i) st_q <= W_FIN;
        W_FIN: st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (st_q == W_TAG) || (st_q == W_DATA) || (st_q == W_UPD);
    mem_we_o    = (st_q == W_UPD);
    mem_addr_o  = tbl_base_i + entry_off + ((st_q == W_TAG) ? ADDR_W'(0) : ADDR_W'(WORD_BYTES));
    mem_wdata_o = pte_q;
    busy_o      = (st_q != W_IDLE) && (st_q != W_FIN);
    done_o      = (st_q == W_FIN);
    hit_o       = hit_q;
    wr_allow_o  = wr_allow_q;
    pte_off_o   = off_q;
    pte_word_o  = pte_q;
    real_addr_o = real_q;
    cmp_o       = cmp_q;
    sec_o       = sec_q;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r7_wb_second_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[REF_BIT] && (mem_addr_o[2:0] == 3'd4));
  a_r8_allow_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_allow_o |-> hit_o);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r5_pass_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_q) |-> $past(idx_q) == LAST_IDX);
endmodule

// File: rtl/hpt_search.sv
module hpt_search
  import hpt_pkg::*;
#(
  parameter int unsigned VSID_W  = 24,
  parameter int unsigned EA_W    = 32,
  parameter int unsigned HASH_W  = 19,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned GRP_SHIFT = $clog2(ENTRIES * ENTRY_BYTES),
  localparam int unsigned CMP_W  = VSID_W + (EA_W - SEG_BITS - PAGE_BITS - API_SHIFT) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VSID_W-1:0] req_vsid_i,
  input  logic [EA_W-1:0]   req_ea_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [ADDR_W-1:0] tbl_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] pte_off_o,
  output logic [PTE_W-1:0]  pte_word_o,
  output logic [EA_W-1:0]   real_addr_o,
  output logic              wr_allow_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [CMP_W-1:0]  cmp_new, cmp_cur;
  logic [ADDR_W-1:0] prim_off, sec_off;
  logic              sec_cur, tag_hit;

  hpt_hash #(
    .VSID_W(VSID_W), .EA_W(EA_W), .HASH_W(HASH_W),
    .ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid_i(req_vsid_i), .ea_i(req_ea_i), .mask_i(tbl_mask_i),
    .cmp_o(cmp_new), .prim_off_o(prim_off), .sec_off_o(sec_off)
  );

  hpt_match #(.CMP_W(CMP_W)) u_match (
    .tag_i(mem_rdata_i), .cmp_i(cmp_cur), .sec_i(sec_cur), .hit_o(tag_hit)
  );

  hpt_walk_ctrl #(
    .EA_W(EA_W), .ADDR_W(ADDR_W), .CMP_W(CMP_W), .ENTRIES(ENTRIES)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ea_i(req_ea_i), .req_store_i(req_store_i),
    .cmp_i(cmp_new), .prim_off_i(prim_off), .sec_off_i(sec_off),
    .tbl_base_i(tbl_base_i), .match_i(tag_hit),
    .cmp_o(cmp_cur), .sec_o(sec_cur),
    .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o),
    .pte_off_o(pte_off_o), .pte_word_o(pte_word_o), .real_addr_o(real_addr_o),
    .wr_allow_o(wr_allow_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );
endmodule

// File: tb/tb_hpt_search.sv
`timescale 1ns/1ps
module tb_hpt_search;
  localparam int MEM_WORDS = 2048;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] MASK = 32'h0000_1FC0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_store, mem_ack;
  logic [23:0] req_vsid;
  logic [31:0] req_ea, mem_rdata;
  logic        busy, done, hit, wr_allow, mem_req, mem_we;
  logic [31:0] pte_off, pte_word, real_addr, mem_addr, mem_wdata;

  hpt_search dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vsid_i(req_vsid),
    .req_ea_i(req_ea), .req_store_i(req_store), .tbl_base_i(BASE), .tbl_mask_i(MASK),
    .busy_o(busy), .done_o(done), .hit_o(hit), .pte_off_o(pte_off),
    .pte_word_o(pte_word), .real_addr_o(real_addr), .wr_allow_o(wr_allow),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] rd_log [16];
  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  bit finished = 0;

  function automatic int widx(logic [31:0] off);
    return int'((off >> 2) & (MEM_WORDS - 1));
  endfunction

  function automatic logic [30:0] cmp_of(logic [23:0] v, logic [31:0] ea);
    return {v, 1'b0, ea[27:22]};
  endfunction

  function automatic logic [31:0] goff(logic [23:0] v, logic [31:0] ea, bit sec);
    logic [18:0] h;
    h = v[18:0] ^ {3'b0, ea[27:12]};
    if (sec) h = ~h;
    return ({13'b0, h} << 6) & MASK;
  endfunction

  function automatic logic [31:0] w0_of(bit valid, logic [23:0] v, bit sec, logic [5:0] api);
    return {valid, v, sec, api};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // memory model with random latency; counts accesses and completion pulses
  initial begin
    int wait_n;
    int k;
    wait_n = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        if (wait_n > 0) begin
          wait_n--;
        end else begin
          k = widx(mem_addr - BASE);
          if (mem_we) begin
            mem[k] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem[k];
            if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
          end
          mem_ack = 1'b1;
          wait_n = int'($urandom % 3);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic clear_groups(logic [23:0] v, logic [31:0] ea);
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 16; i++) mem[widx(goff(v, ea, p[0]) + 32'(4 * i))] = '0;
  endtask

  task automatic put(logic [23:0] v, logic [31:0] ea, bit sec, int slot,
                     logic [31:0] w0, logic [31:0] w1);
    logic [31:0] a;
    a = goff(v, ea, sec) + 32'(8 * slot);
    mem[widx(a)] = w0;
    mem[widx(a + 4)] = w1;
  endtask

  task automatic ref_search(logic [23:0] v, logic [31:0] ea, output bit fnd,
                            output logic [31:0] off, output int nrd);
    logic [31:0] a, w;
    fnd = 0; off = '0; nrd = 0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++)
        if (!fnd) begin
          a = goff(v, ea, p[0]) + 32'(8 * i);
          w = mem[widx(a)];
          nrd++;
          if (w[31] && (w[6] == p[0]) && ({w[30:7], 1'b0, w[5:0]} == cmp_of(v, ea))) begin
            fnd = 1; off = a; nrd++;
          end
        end
  endtask

  task automatic launch(logic [23:0] v, logic [31:0] ea, bit st, bit inject);
    int guard;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    req_vsid = v; req_ea = ea; req_store = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      chk("R11 busy during scan", 32'(busy), 32'd1);
      req_vsid = ~v; req_ea = ~ea; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) begin
      checks++; fails++;
      $display("FAIL lookup timeout: actual no done expected done");
    end
    @(negedge clk);
  endtask

  task automatic lookup(string lbl, logic [23:0] v, logic [31:0] ea, bit st, bit inject);
    bit fnd;
    logic [31:0] off, old_w, new_w;
    int nrd;
    ref_search(v, ea, fnd, off, nrd);
    old_w = mem[widx(off + 4)];
    new_w = old_w | 32'h100 | (st ? 32'h80 : 32'h0);
    launch(v, ea, st, inject);
    chk({lbl, " R3 hit flag"}, 32'(hit), 32'(fnd));
    chk({lbl, " R2 read count"}, 32'(rd_cnt), 32'(nrd));
    chk({lbl, " R11 single done"}, 32'(done_cnt), 32'd1);
    chk({lbl, " R8 write allow"}, 32'(wr_allow), 32'(fnd && st));
    if (fnd) begin
      chk({lbl, " R10 offset"}, pte_off, off);
      chk({lbl, " R10 word"}, pte_word, new_w);
      chk({lbl, " R9 real addr"}, real_addr, {old_w[31:12], ea[11:0]});
      chk({lbl, " R7 stored word"}, mem[widx(off + 4)], new_w);
      chk({lbl, " R7 write count"}, 32'(wr_cnt), 32'(new_w != old_w));
    end else begin
      chk({lbl, " R6 no write"}, 32'(wr_cnt), 32'd0);
      chk({lbl, " R6 reads"}, 32'(rd_cnt), 32'd16);
    end
  endtask

  initial begin
    logic [23:0] v;
    logic [31:0] ea;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_vsid = '0; req_ea = '0;
    repeat (4) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 hit", 32'(hit), 32'd0);
    chk("R1 allow", 32'(wr_allow), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 decoys before a hit whose referenced bit is already set (no write)
    v = 24'h123456; ea = 32'h3ABC_D123;
    clear_groups(v, ea);
    put(v, ea, 0, 1, w0_of(1, v, 1, ea[27:22]), 32'h1111_1000);
    put(v, ea, 0, 2, w0_of(0, v, 0, ea[27:22]), 32'h2222_2000);
    put(v, ea, 0, 3, w0_of(1, v ^ 24'h1, 0, ea[27:22]), 32'h3333_3000);
    put(v, ea, 0, 5, w0_of(1, v, 0, ea[27:22]), 32'hCAFE_5100);
    lookup("R3 decoys", v, ea, 0, 0);

    // R4 two matches, lowest wins; store sets changed bit
    v = 24'h0ABCDE; ea = 32'h8765_4321;
    clear_groups(v, ea);
    put(v, ea, 0, 4, w0_of(1, v, 0, ea[27:22]), 32'hAAAA_A000);
    put(v, ea, 0, 6, w0_of(1, v, 0, ea[27:22]), 32'hBBBB_B000);
    lookup("R4 first match", v, ea, 1, 0);
    chk("R4 later entry untouched", mem[widx(goff(v, ea, 0) + 52)], 32'hBBBB_B000);

    // R5 secondary pass; flag-clear entry in secondary group is skipped
    v = 24'hFEDCBA; ea = 32'h1234_5FFF;
    clear_groups(v, ea);
    put(v, ea, 0, 0, w0_of(1, v, 0, ~ea[27:22]), 32'h4444_4000);
    put(v, ea, 1, 2, w0_of(1, v, 0, ea[27:22]), 32'h5555_5000);
    put(v, ea, 1, 7, w0_of(1, v, 1, ea[27:22]), 32'h6666_6000);
    lookup("R5 secondary", v, ea, 0, 0);
    chk("R5 offset in secondary group", pte_off, goff(v, ea, 1) + 56);

    // R6 full miss, check read order (R2)
    v = 24'h00F00F; ea = 32'h5A5A_5A5A;
    clear_groups(v, ea);
    lookup("R6 miss", v, ea, 1, 0);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R2 read order %0d", i), rd_log[i],
          BASE + goff(v, ea, i >= 8) + 32'(8 * (i % 8)));

    // R11 request while busy ignored
    lookup("R11 inject", v, ea, 0, 1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int choice, slot;
      v = 24'($urandom); ea = $urandom;
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < 8; i++)
          put(v, ea, p[0], i, $urandom, $urandom);
      choice = int'($urandom % 3);
      slot = int'($urandom % 8);
      if (choice != 0)
        put(v, ea, choice == 2, slot, w0_of(1, v, choice == 2, ea[27:22]),
            $urandom & 32'hFFFF_FE7F | ($urandom & 32'h180));
      lookup($sformatf("rand %0d", n), v, ea, $urandom % 2, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule